// File: doc/BRIEF.md
# Serial EEPROM Configuration Auto-Loader

After reset this block fills a switch's control registers from a configuration image held in an external two-wire serial EEPROM. It issues one byte-read request at a time on a simple request/acknowledge interface; a separate bit-level master turns each request into bus traffic. The image sizes itself: its first byte names the last address to read, so the load stops there without any length parameter.

Each byte is decoded as it arrives. The decoded fields are the aging time, one VLAN membership mask per port, a flooding target per port (two targets packed in each byte), the broadcast threshold, the high and low pause thresholds, a port-disable mask and an enhanced-backpressure enable. From address 0x20 on, the image holds seven-byte static MAC entries. Each complete entry is handed to an address table as a single-cycle write strobe together with its MAC and port.

Values have three sources, each overriding the one before: board straps first, then the EEPROM image, then management writes. Management writes are refused until the done flag is raised. A flooding code that names no real port is replaced with "flood to all" and raises a sticky error flag.

Top module: `eecfg_loader`

## Requirements
- R1: With `strap_ee_en` and `strap_autoload` both high, the block reads address 0x00 and then 0x01 up to the last address in ascending order. Address 0x00 holds that last address. `rd_req` stays high with `rd_addr` unchanged until a cycle with `rd_ack` high, and that cycle's `rd_data` is the byte. A value of 0x00 in byte 0x00 ends the load after byte 0x00.
- R2: If either of those two straps is low, no read is requested. `cfg_done` is high from the first clock edge after reset is released.
- R3: While reset is held, the fields take these values: aging time 300, every flooding target 0xF, broadcast threshold 0xFF, pause thresholds 0x74/0x30, port-disable 0, enhanced backpressure 0, and each port's VLAN mask containing every port except itself. At the first edge after reset, every flooding target takes `strap_flood`. At the same edge the pause thresholds become 0x74 (high) and 0x30 (low) if `strap_big_mem` is 1, or 0x2E and 0x18 if it is 0. Fields the image does not reach keep these values.
- R4: Image decode is as follows. 0x01 is aging time bits 7:0 and 0x02 is bits 15:8. 0x03+p is the VLAN mask of port p (bit q set means port q is a member). 0x0F is the broadcast threshold, 0x10 the high pause threshold, 0x11 the low pause threshold and 0x12 the port-disable mask. Bit 0 of 0x13 is enhanced backpressure. Addresses 0x14 to 0x1F have no effect. A field changes at the clock edge that accepts its byte.
- R5: Bytes 0x0B+k carry the flooding target of port 2k in bits 3:0 and of port 2k+1 in bits 7:4. A code of 0 to 7 names a port, and 0xF means all other ports.
- R6: A flooding code from 0x8 to 0xE, from any source (strap, image or management), is stored as 0xF. It also sets `flood_err`, which stays set until reset.
- R7: From 0x20, every seven bytes form one entry. The first six bytes carry MAC bits 7:0, 15:8, up to 47:40, and bits 2:0 of the seventh byte give the port. `st_we` is high for exactly the one cycle after the seventh byte is accepted, with `st_mac` and `st_port` valid. An entry cut short by the end of the image produces no strobe.
- R8: `cfg_done` rises in the cycle after the last byte is accepted and stays high until reset. `rd_req` is low whenever `cfg_done` is high.
- R9: A management write (`mgmt_we`) is ignored while `cfg_done` is low. After that it overrides the field at the next edge. Select codes: 0 sets aging time; 1 sets {high, low} pause thresholds; 2 sets the flooding targets of ports 0-3 and 3 those of ports 4-7, with port 4g+i in data bits 4i+3:4i; 4 sets the broadcast threshold in bits 7:0 and enhanced backpressure in bit 8; 5 sets the port-disable mask; 16+p sets the VLAN mask of port p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_ee_en | input | 1 | EEPROM interface present strap |
| strap_autoload | input | 1 | Auto-load enable strap |
| strap_big_mem | input | 1 | Large buffer memory strap, selects default pause thresholds |
| strap_flood | input | 4 | Strap flooding target for all ports |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | 8 | EEPROM byte address |
| rd_ack | input | 1 | Read completion, one cycle |
| rd_data | input | 8 | Byte returned with rd_ack |
| mgmt_we | input | 1 | Management write strobe |
| mgmt_sel | input | 5 | Management field select |
| mgmt_wdata | input | 16 | Management write data |
| cfg_done | output | 1 | Load finished |
| age_time | output | 16 | Aging time |
| vlan_mask | output | 64 | VLAN masks, port p in bits 8p+7:8p |
| flood_tgt | output | 32 | Flooding targets, port p in bits 4p+3:4p |
| bcast_th | output | 8 | Broadcast threshold |
| pause_hi | output | 8 | High pause threshold |
| pause_lo | output | 8 | Low pause threshold |
| port_dis | output | 8 | Port-disable mask |
| enh_bp | output | 1 | Enhanced backpressure enable |
| flood_err | output | 1 | Sticky illegal flooding code flag |
| st_we | output | 1 | Static entry write strobe |
| st_mac | output | 48 | Static entry MAC |
| st_port | output | 3 | Static entry port |

## Verification
Two cases are hard to reach from the ports. One is a static entry that is cut off because the image ends partway through it. The other is a management write arriving in the middle of the load. The bench builds images whose end byte points to 0x2D (two full entries) and to 0x23 (a partial one). It also varies the acknowledge latency, so the strobe and the done edge fall at different distances from the request. Management writes are issued while requests are still pending. Illegal flooding codes are injected through all three sources, each one after reset, so the sticky flag's cause is known.

// File: rtl/eecfg_pkg.sv
package eecfg_pkg;

    localparam int BYTE_W = 8;
    localparam int MSEL_W = 5;

    typedef enum logic [1:0] {
        PH_INIT = 2'd0,
        PH_LOAD = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    localparam logic [MSEL_W-1:0] MSEL_AGE    = 5'd0;
    localparam logic [MSEL_W-1:0] MSEL_PAUSE  = 5'd1;
    localparam logic [MSEL_W-1:0] MSEL_FLOOD0 = 5'd2;
    localparam logic [MSEL_W-1:0] MSEL_BCAST  = 5'd4;
    localparam logic [MSEL_W-1:0] MSEL_PDIS   = 5'd5;
    localparam logic [MSEL_W-1:0] MSEL_VLAN0  = 5'd16;

    // a code naming no existing port, other than the all-ports code
    function automatic logic flood_bad(input logic [3:0] n, input int nports);
        return (int'(n) >= nports) && (n != 4'hF);
    endfunction

    function automatic logic [3:0] flood_fix(input logic [3:0] n, input int nports);
        return flood_bad(n, nports) ? 4'hF : n;
    endfunction

endpackage

// File: rtl/eecfg_seq.sv
module eecfg_seq
    import eecfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_ee_en,
    input  logic              strap_autoload,
    input  logic              rd_ack,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              rd_req,
    output logic [BYTE_W-1:0] rd_addr,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_addr,
    output logic [BYTE_W-1:0] byte_data,
    output logic              strap_load,
    output logic              done
);

    typedef struct packed {
        phase_e            phase;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] last;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.phase)
            PH_INIT: begin
                s_d.addr  = '0;
                s_d.phase = (strap_ee_en && strap_autoload) ? PH_LOAD : PH_DONE;
            end
            PH_LOAD: begin
                if (rd_ack) begin
                    if (s_q.addr == '0) begin
                        s_d.last = rd_data;
                        if (rd_data == '0) s_d.phase = PH_DONE;
                        else               s_d.addr  = BYTE_W'(1);
                    end else if (s_q.addr == s_q.last) begin
                        s_d.phase = PH_DONE;
                    end else begin
                        s_d.addr = s_q.addr + 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{phase: PH_INIT, addr: '0, last: '0};
        else        s_q <= s_d;
    end

    assign rd_req     = (s_q.phase == PH_LOAD);
    assign rd_addr    = s_q.addr;
    assign byte_vld   = rd_req && rd_ack;
    assign byte_addr  = s_q.addr;
    assign byte_data  = rd_data;
    assign strap_load = (s_q.phase == PH_INIT);
    assign done       = (s_q.phase == PH_DONE);

    // R1
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

    // R1
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> done || (rd_addr == BYTE_W'($past(rd_addr) + 1'b1)));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R8
    no_req_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_req);

endmodule

// File: rtl/eecfg_static.sv
module eecfg_static
    import eecfg_pkg::*;
#(
    parameter int NPORTS      = 8,
    parameter int BASE_ADDR   = 32,
    parameter int ENTRY_BYTES = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_addr,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              st_we,
    output logic [(ENTRY_BYTES-1)*BYTE_W-1:0] st_mac,
    output logic [$clog2(NPORTS)-1:0]         st_port
);

    localparam int MAC_BYTES = ENTRY_BYTES - 1;
    localparam int MAC_W     = MAC_BYTES * BYTE_W;
    localparam int SLOT_W    = $clog2(ENTRY_BYTES);
    localparam int PORT_W    = $clog2(NPORTS);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [MAC_W-1:0]  acc;
        logic              we;
        logic [MAC_W-1:0]  mac;
        logic [PORT_W-1:0] port;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.we = 1'b0;
        if (byte_vld && int'(byte_addr) >= BASE_ADDR) begin
            if (s_q.slot == SLOT_W'(MAC_BYTES)) begin
                s_d.we   = 1'b1;
                s_d.mac  = s_q.acc;
                s_d.port = byte_data[PORT_W-1:0];
                s_d.slot = '0;
            end else begin
                s_d.acc[s_q.slot*BYTE_W +: BYTE_W] = byte_data;
                s_d.slot = s_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign st_we   = s_q.we;
    assign st_mac  = s_q.mac;
    assign st_port = s_q.port;

    // R7
    st_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |=> !st_we);

endmodule

// File: rtl/eecfg_regs.sv
module eecfg_regs
    import eecfg_pkg::*;
#(
    parameter int          NPORTS    = 8,
    parameter logic [15:0] AGE_DEF   = 16'd300,
    parameter logic [7:0]  BCAST_DEF = 8'hFF,
    parameter logic [7:0]  PHI_BIG   = 8'h74,
    parameter logic [7:0]  PLO_BIG   = 8'h30,
    parameter logic [7:0]  PHI_SMALL = 8'h2E,
    parameter logic [7:0]  PLO_SMALL = 8'h18
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     strap_load,
    input  logic                     strap_big_mem,
    input  logic [3:0]               strap_flood,
    input  logic                     byte_vld,
    input  logic [BYTE_W-1:0]        byte_addr,
    input  logic [BYTE_W-1:0]        byte_data,
    input  logic                     done,
    input  logic                     mgmt_we,
    input  logic [MSEL_W-1:0]        mgmt_sel,
    input  logic [15:0]              mgmt_wdata,
    output logic [15:0]              age_time,
    output logic [NPORTS*NPORTS-1:0] vlan_mask,
    output logic [NPORTS*4-1:0]      flood_tgt,
    output logic [7:0]               bcast_th,
    output logic [7:0]               pause_hi,
    output logic [7:0]               pause_lo,
    output logic [NPORTS-1:0]        port_dis,
    output logic                     enh_bp,
    output logic                     flood_err
);

    localparam int A_AGE_LO = 1;
    localparam int A_AGE_HI = 2;
    localparam int A_VLAN   = 3;
    localparam int A_FLOOD  = A_VLAN + NPORTS;
    localparam int A_BCAST  = A_FLOOD + NPORTS / 2;
    localparam int A_PHI    = A_BCAST + 1;
    localparam int A_PLO    = A_BCAST + 2;
    localparam int A_PDIS   = A_BCAST + 3;
    localparam int A_SYSC   = A_BCAST + 4;

    function automatic logic [NPORTS*NPORTS-1:0] vlan_default();
        logic [NPORTS*NPORTS-1:0] v;
        for (int p = 0; p < NPORTS; p++) begin
            v[p*NPORTS +: NPORTS] = ~(NPORTS'(1) << p);
        end
        return v;
    endfunction

    localparam logic [NPORTS*NPORTS-1:0] VLAN_DEF = vlan_default();

    typedef struct packed {
        logic [15:0]              age;
        logic [NPORTS*NPORTS-1:0] vlan;
        logic [NPORTS*4-1:0]      flood;
        logic [7:0]               bcast;
        logic [7:0]               phi;
        logic [7:0]               plo;
        logic [NPORTS-1:0]        pdis;
        logic                     enh;
        logic                     err;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;

        // lowest priority: straps
        if (strap_load) begin
            for (int p = 0; p < NPORTS; p++) begin
                r_d.flood[p*4 +: 4] = flood_fix(strap_flood, NPORTS);
            end
            r_d.err = r_d.err | flood_bad(strap_flood, NPORTS);
            r_d.phi = strap_big_mem ? PHI_BIG : PHI_SMALL;
            r_d.plo = strap_big_mem ? PLO_BIG : PLO_SMALL;
        end

        // image bytes
        if (byte_vld) begin
            if (int'(byte_addr) == A_AGE_LO) r_d.age[7:0]  = byte_data;
            if (int'(byte_addr) == A_AGE_HI) r_d.age[15:8] = byte_data;
            for (int p = 0; p < NPORTS; p++) begin
                if (int'(byte_addr) == A_VLAN + p)
                    r_d.vlan[p*NPORTS +: NPORTS] = byte_data[NPORTS-1:0];
            end
            for (int k = 0; k < NPORTS / 2; k++) begin
                if (int'(byte_addr) == A_FLOOD + k) begin
                    r_d.flood[(2*k)*4 +: 4]   = flood_fix(byte_data[3:0], NPORTS);
                    r_d.flood[(2*k+1)*4 +: 4] = flood_fix(byte_data[7:4], NPORTS);
                    r_d.err = r_d.err | flood_bad(byte_data[3:0], NPORTS)
                                      | flood_bad(byte_data[7:4], NPORTS);
                end
            end
            if (int'(byte_addr) == A_BCAST) r_d.bcast = byte_data;
            if (int'(byte_addr) == A_PHI)   r_d.phi   = byte_data;
            if (int'(byte_addr) == A_PLO)   r_d.plo   = byte_data;
            if (int'(byte_addr) == A_PDIS)  r_d.pdis  = byte_data[NPORTS-1:0];
            if (int'(byte_addr) == A_SYSC)  r_d.enh   = byte_data[0];
        end

        // highest priority: management, only once loading is over
        if (done && mgmt_we) begin
            if (mgmt_sel == MSEL_AGE) r_d.age = mgmt_wdata;
            if (mgmt_sel == MSEL_PAUSE) begin
                r_d.phi = mgmt_wdata[15:8];
                r_d.plo = mgmt_wdata[7:0];
            end
            for (int p = 0; p < NPORTS; p++) begin
                if (int'(mgmt_sel) == int'(MSEL_FLOOD0) + p / 4) begin
                    r_d.flood[p*4 +: 4] = flood_fix(mgmt_wdata[(p%4)*4 +: 4], NPORTS);
                    r_d.err = r_d.err | flood_bad(mgmt_wdata[(p%4)*4 +: 4], NPORTS);
                end
                if (int'(mgmt_sel) == int'(MSEL_VLAN0) + p)
                    r_d.vlan[p*NPORTS +: NPORTS] = mgmt_wdata[NPORTS-1:0];
            end
            if (mgmt_sel == MSEL_BCAST) begin
                r_d.bcast = mgmt_wdata[7:0];
                r_d.enh   = mgmt_wdata[8];
            end
            if (mgmt_sel == MSEL_PDIS) r_d.pdis = mgmt_wdata[NPORTS-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{age: AGE_DEF, vlan: VLAN_DEF, flood: '1, bcast: BCAST_DEF,
                     phi: PHI_BIG, plo: PLO_BIG, pdis: '0, enh: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign age_time  = r_q.age;
    assign vlan_mask = r_q.vlan;
    assign flood_tgt = r_q.flood;
    assign bcast_th  = r_q.bcast;
    assign pause_hi  = r_q.phi;
    assign pause_lo  = r_q.plo;
    assign port_dis  = r_q.pdis;
    assign enh_bp    = r_q.enh;
    assign flood_err = r_q.err;

    // R9
    mgmt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done && mgmt_we && !strap_load && !byte_vld |=> $stable(r_q));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flood_err |=> flood_err);

    generate
        for (genvar p = 0; p < NPORTS; p++) begin : g_flood_chk
            // R6
            flood_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !flood_bad(flood_tgt[p*4 +: 4], NPORTS));
        end
    endgenerate

endmodule

// File: rtl/eecfg_loader.sv
module eecfg_loader
    import eecfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strap_ee_en,
    input  logic        strap_autoload,
    input  logic        strap_big_mem,
    input  logic [3:0]  strap_flood,
    output logic        rd_req,
    output logic [7:0]  rd_addr,
    input  logic        rd_ack,
    input  logic [7:0]  rd_data,
    input  logic        mgmt_we,
    input  logic [4:0]  mgmt_sel,
    input  logic [15:0] mgmt_wdata,
    output logic        cfg_done,
    output logic [15:0] age_time,
    output logic [63:0] vlan_mask,
    output logic [31:0] flood_tgt,
    output logic [7:0]  bcast_th,
    output logic [7:0]  pause_hi,
    output logic [7:0]  pause_lo,
    output logic [7:0]  port_dis,
    output logic        enh_bp,
    output logic        flood_err,
    output logic        st_we,
    output logic [47:0] st_mac,
    output logic [2:0]  st_port
);

    localparam int NPORTS      = 8;
    localparam int STATIC_BASE = 32;
    localparam int ENTRY_BYTES = 7;

    logic              byte_vld;
    logic [BYTE_W-1:0] byte_addr;
    logic [BYTE_W-1:0] byte_data;
    logic              strap_load;
    logic              done;

    eecfg_seq i_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .strap_ee_en    (strap_ee_en),
        .strap_autoload (strap_autoload),
        .rd_ack         (rd_ack),
        .rd_data        (rd_data),
        .rd_req         (rd_req),
        .rd_addr        (rd_addr),
        .byte_vld       (byte_vld),
        .byte_addr      (byte_addr),
        .byte_data      (byte_data),
        .strap_load     (strap_load),
        .done           (done)
    );

    eecfg_regs #(.NPORTS(NPORTS)) i_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .strap_load    (strap_load),
        .strap_big_mem (strap_big_mem),
        .strap_flood   (strap_flood),
        .byte_vld      (byte_vld),
        .byte_addr     (byte_addr),
        .byte_data     (byte_data),
        .done          (done),
        .mgmt_we       (mgmt_we),
        .mgmt_sel      (mgmt_sel),
        .mgmt_wdata    (mgmt_wdata),
        .age_time      (age_time),
        .vlan_mask     (vlan_mask),
        .flood_tgt     (flood_tgt),
        .bcast_th      (bcast_th),
        .pause_hi      (pause_hi),
        .pause_lo      (pause_lo),
        .port_dis      (port_dis),
        .enh_bp        (enh_bp),
        .flood_err     (flood_err)
    );

    eecfg_static #(
        .NPORTS      (NPORTS),
        .BASE_ADDR   (STATIC_BASE),
        .ENTRY_BYTES (ENTRY_BYTES)
    ) i_static (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .byte_addr (byte_addr),
        .byte_data (byte_data),
        .st_we     (st_we),
        .st_mac    (st_mac),
        .st_port   (st_port)
    );

    assign cfg_done = done;

endmodule

// File: tb/test_eecfg_loader.sv
`timescale 1ns/1ps
module test_eecfg_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_ee_en = 1'b0, strap_autoload = 1'b0, strap_big_mem = 1'b0;
    logic [3:0]  strap_flood = 4'h0;
    logic        rd_req;
    logic [7:0]  rd_addr;
    logic        rd_ack = 1'b0;
    logic [7:0]  rd_data = 8'h00;
    logic        mgmt_we = 1'b0;
    logic [4:0]  mgmt_sel = 5'd0;
    logic [15:0] mgmt_wdata = 16'h0;
    logic        cfg_done, enh_bp, flood_err, st_we;
    logic [15:0] age_time;
    logic [63:0] vlan_mask;
    logic [31:0] flood_tgt;
    logic [7:0]  bcast_th, pause_hi, pause_lo, port_dis;
    logic [47:0] st_mac;
    logic [2:0]  st_port;

    always #2.5 clk = ~clk;

    eecfg_loader i_eecfg_loader (.*);

    // reference state
    logic [7:0]  img [256];
    int          n_chk = 0, n_fail = 0;
    int          m_phase, m_addr, m_last, lat, ack_wait;
    logic [15:0] e_age;
    logic [63:0] e_vlan;
    logic [31:0] e_flood;
    logic [7:0]  e_bcast, e_phi, e_plo, e_pdis;
    logic        e_enh, e_err, e_stwe;
    logic [47:0] e_macbuf, e_mac;
    logic [2:0]  e_port;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    task automatic compare();
        chk(cfg_done == (m_phase == 2), "R8 cfg_done", 64'(cfg_done), 64'(m_phase == 2));
        chk(rd_req == (m_phase == 1), "R1/R2 rd_req", 64'(rd_req), 64'(m_phase == 1));
        if (m_phase == 1) chk(rd_addr == 8'(m_addr), "R1 rd_addr", 64'(rd_addr), 64'(m_addr));
        chk(age_time == e_age, "R4 age_time", 64'(age_time), 64'(e_age));
        chk(vlan_mask == e_vlan, "R4 vlan_mask", vlan_mask, e_vlan);
        chk(flood_tgt == e_flood, "R5 flood_tgt", 64'(flood_tgt), 64'(e_flood));
        chk(bcast_th == e_bcast && port_dis == e_pdis && enh_bp == e_enh, "R4 bcast/pdis/enh",
            {47'h0, enh_bp, port_dis, bcast_th}, {47'h0, e_enh, e_pdis, e_bcast});
        chk(pause_hi == e_phi && pause_lo == e_plo, "R3 pause", {pause_hi, pause_lo}, {e_phi, e_plo});
        chk(flood_err == e_err, "R6 flood_err", 64'(flood_err), 64'(e_err));
        chk(st_we == e_stwe, "R7 st_we", 64'(st_we), 64'(e_stwe));
        if (e_stwe) chk(st_mac == e_mac && st_port == e_port, "R7 st_mac/st_port",
                        {13'h0, st_port, st_mac}, {13'h0, e_port, e_mac});
    endtask

    function automatic logic [3:0] m_fix(input logic [3:0] n);
        if (n > 4'd7 && n < 4'd15) begin
            e_err = 1'b1;
            return 4'hF;
        end
        return n;
    endfunction

    task automatic apply_byte(input int a, input logic [7:0] d);
        if (a == 1) e_age[7:0] = d;
        else if (a == 2) e_age[15:8] = d;
        else if (a >= 3 && a <= 10) e_vlan[(a-3)*8 +: 8] = d;
        else if (a >= 11 && a <= 14) begin
            e_flood[(a-11)*8 +: 4]     = m_fix(d[3:0]);
            e_flood[(a-11)*8 + 4 +: 4] = m_fix(d[7:4]);
        end
        else if (a == 15) e_bcast = d;
        else if (a == 16) e_phi = d;
        else if (a == 17) e_plo = d;
        else if (a == 18) e_pdis = d;
        else if (a == 19) e_enh = d[0];
        else if (a >= 32) begin
            if ((a - 32) % 7 == 6) begin
                e_stwe = 1'b1;
                e_mac  = e_macbuf;
                e_port = d[2:0];
            end else begin
                e_macbuf[((a - 32) % 7)*8 +: 8] = d;
            end
        end
    endtask

    task automatic apply_mgmt(input logic [4:0] s, input logic [15:0] w);
        case (s)
            5'd0: e_age = w;
            5'd1: begin e_phi = w[15:8]; e_plo = w[7:0]; end
            5'd2: for (int i = 0; i < 4; i++) e_flood[i*4 +: 4] = m_fix(w[i*4 +: 4]);
            5'd3: for (int i = 0; i < 4; i++) e_flood[16 + i*4 +: 4] = m_fix(w[i*4 +: 4]);
            5'd4: begin e_bcast = w[7:0]; e_enh = w[8]; end
            5'd5: e_pdis = w[7:0];
            default: if (s >= 5'd16 && s <= 5'd23) e_vlan[(s-16)*8 +: 8] = w[7:0];
        endcase
    endtask

    // one cycle, entered and left at a falling edge
    task automatic tick(input logic we = 1'b0, input logic [4:0] sel = 5'd0, input logic [15:0] wd = 16'h0);
        bit was_done;
        compare();
        mgmt_we = we; mgmt_sel = sel; mgmt_wdata = wd;
        if (rd_ack) rd_ack = 1'b0;
        else if (rd_req) begin
            if (ack_wait >= lat) begin
                rd_ack = 1'b1; rd_data = img[rd_addr]; ack_wait = 0;
            end else ack_wait++;
        end
        was_done = (m_phase == 2);
        e_stwe = 1'b0;
        if (m_phase == 0) begin
            for (int p = 0; p < 8; p++) e_flood[p*4 +: 4] = m_fix(strap_flood);
            e_phi = strap_big_mem ? 8'h74 : 8'h2E;
            e_plo = strap_big_mem ? 8'h30 : 8'h18;
            m_phase = (strap_ee_en && strap_autoload) ? 1 : 2;
            m_addr = 0;
        end else if (m_phase == 1 && rd_ack) begin
            if (m_addr == 0) begin
                m_last = int'(img[0]);
                if (m_last == 0) m_phase = 2; else m_addr = 1;
            end else begin
                apply_byte(m_addr, img[m_addr]);
                if (m_addr == m_last) m_phase = 2; else m_addr++;
            end
        end
        if (was_done && we) apply_mgmt(sel, wd);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic ee, input logic al, input logic big, input logic [3:0] fl, input int latency);
        @(negedge clk);
        rst_n = 1'b0; rd_ack = 1'b0; mgmt_we = 1'b0;
        strap_ee_en = ee; strap_autoload = al; strap_big_mem = big; strap_flood = fl;
        lat = latency; ack_wait = 0; m_phase = 0; m_addr = 0; m_last = 0;
        e_age = 16'd300; e_flood = '1; e_bcast = 8'hFF; e_phi = 8'h74; e_plo = 8'h30;
        e_pdis = 8'h00; e_enh = 1'b0; e_err = 1'b0; e_stwe = 1'b0; e_macbuf = '0; e_mac = '0; e_port = '0;
        for (int p = 0; p < 8; p++) e_vlan[p*8 +: 8] = ~(8'h01 << p);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_load(input int limit);
        for (int i = 0; i < limit && m_phase != 2; i++) tick();
        tick(); tick();
    endtask

    task automatic fill_img();
        for (int i = 0; i < 256; i++) img[i] = 8'((i * 37 + 11) & 8'hFF);
    endtask

    initial begin
        // straps off: no load, strap values, management afterwards (R2 R3 R9 R6)
        fill_img();
        do_reset(1'b1, 1'b0, 1'b0, 4'h3, 0);
        tick(); tick(); tick();
        tick(1'b1, 5'd0, 16'h1234);
        tick(1'b1, 5'd1, 16'h5566);
        tick(1'b1, 5'd2, 16'h7F20);
        tick(1'b1, 5'd3, 16'h00A1);
        tick(1'b1, 5'd4, 16'h0140);
        tick(1'b1, 5'd5, 16'h0081);
        tick(1'b1, 5'd19, 16'h0055);
        tick(); tick();

        // full basic image, big memory, management during load ignored (R1 R4 R5 R9)
        fill_img();
        img[0] = 8'h13; img[1] = 8'h2C; img[2] = 8'h01;
        img[3] = 8'hFE; img[4] = 8'hFD; img[5] = 8'hFB; img[6] = 8'hF7;
        img[7] = 8'hEF; img[8] = 8'hDF; img[9] = 8'hBF; img[10] = 8'h7F;
        img[11] = 8'h3F; img[12] = 8'h25; img[13] = 8'h71; img[14] = 8'h06;
        img[15] = 8'h40; img[16] = 8'h66; img[17] = 8'h22; img[18] = 8'h0C; img[19] = 8'h01;
        do_reset(1'b1, 1'b1, 1'b1, 4'h0, 2);
        tick(); tick();
        tick(1'b1, 5'd0, 16'hBEEF);
        tick(1'b1, 5'd16, 16'h0000);
        run_load(200);
        tick(1'b1, 5'd17, 16'h00AA);
        tick(1'b1, 5'd1, 16'h1122);
        tick(); tick();

        // static entries, reserved bytes, illegal flood nibbles (R4 R6 R7)
        fill_img();
        img[0] = 8'h2D; img[12] = 8'hC9; img[19] = 8'h00;
        for (int i = 0; i < 6; i++) img[32 + i] = 8'(8'h10 + i);
        img[38] = 8'hFD;
        for (int i = 0; i < 6; i++) img[39 + i] = 8'(8'hA0 + 3*i);
        img[45] = 8'h02;
        do_reset(1'b1, 1'b1, 1'b0, 4'h5, 0);
        run_load(400);

        // partial static entry, no strobe (R7)
        fill_img();
        img[0] = 8'h23;
        do_reset(1'b1, 1'b1, 1'b1, 4'h7, 1);
        run_load(400);

        // end byte of zero (R1 R8)
        fill_img();
        img[0] = 8'h00;
        do_reset(1'b1, 1'b1, 1'b0, 4'hF, 3);
        run_load(50);

        // illegal strap flooding code, interface strap off (R2 R6)
        fill_img();
        img[0] = 8'h04;
        do_reset(1'b0, 1'b1, 1'b1, 4'hA, 0);
        tick(); tick(); tick();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule